// File: doc/BRIEF.md
# SMBus Transaction Register Front End

This block is a 40-byte register window that software uses to start SMBus transactions and to collect their results. The window starts at a parameterised base address in a byte-addressed space. Software fills in the device address, the command byte, the outgoing data bytes and, for block writes, the byte count. It then writes a protocol selector to launch the transaction. The block validates the request before anything reaches the wire. It rejects reserved selectors, devices or address/command pairs that a parameterised filter table blocks, and block lengths outside the legal range. Only a request that passes is handed to an external bus engine through a valid/ready request port.

When the engine answers, the block finishes in a fixed order. It first writes the status byte. On the next cycle it returns the protocol register to idle. It pulses the completion event only once the protocol register reads idle. The engine moves received bytes into the data array through its own byte port and reports the received block length.

Independently of transactions, the block latches one SMBus alarm message addressed to the host. It keeps that message until software acknowledges it.

Top module: `smbx_host_regs`

## Requirements
- R1: After reset every register in the window reads 0x00, `req_valid` is low and `done_evt` is low.
- R2: Window offsets are relative to parameter BASE: 0 protocol, 1 status, 2 address, 3 command, 4..35 data bytes 0..31, 36 count, 37 alarm sender, 38/39 alarm bytes 0/1. A read outside BASE..BASE+39 returns 0x00, and a write there changes nothing.
- R3: A nonzero write to the protocol register while idle starts a transaction and clears the done bit and the code field of the status register, keeping the alarm bit. Writing 0x00 starts nothing.
- R4: On completion the status byte is written one cycle before the protocol register returns to 0x00. `done_evt` is a one-cycle pulse in the first cycle in which the protocol register reads 0x00.
- R5: Status layout is bit 7 done, bit 6 alarm, bit 5 zero and bits 4:0 result code. Done is 1 exactly when the code is 0x00.
- R6: Protocol bits 6:0 outside 0x02..0x0D are reserved. They finish with code 0x19 and issue no request. Reserved selectors take precedence over all other checks.
- R7: A device address in the blocked-device table finishes with code 0x17. Otherwise, for a protocol that sends a command byte (0x04, 0x06..0x0D), a blocked address/command pair finishes with 0x12. Neither issues a request. The device check wins over the command and length checks.
- R8: Block write (0x0A) needs a count of 1..32, and the combined block write/read call (0x0D) needs 1..31. Other counts finish with code 0x13 and issue no request.
- R9: On a response to block read (0x0B) or 0x0D, the count register takes the returned length. If the engine code is 0x00 and that length is 0, or above 32 (0x0B) or above 32 minus the write count (0x0D), the code becomes 0x13.
- R10: `req_kind` is protocol bits 6:0 and `req_pec` is protocol bit 7. `req_dev` is address register bits 7:1. `req_cmd` is the command register and `req_count` is count bits 5:0. `req_valid` holds until `req_ready`. The engine's nonzero code is reported unchanged.
- R11: While a transaction is in flight, software writes to every register except the status register are ignored.
- R12: An alarm whose destination is HOST_ADDR (0x08) while the alarm bit is clear stores the sender in alarm-sender bits 7:1 and the two data bytes, and sets the alarm bit. While the bit is set, later alarms leave the stored message unchanged. Alarms to other destinations are ignored.
- R13: Writing 0x00 to the status register clears the alarm bit, done bit and code. Other status writes are ignored.
- R14: The engine reads data byte `eng_rd_idx` combinationally on `eng_rd_byte` and writes data bytes through `eng_wr_en`/`eng_wr_idx`/`eng_wr_byte`, visible to software on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_addr | input | AW | Software byte address |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Software read data (combinational) |
| req_valid | output | 1 | Request to bus engine pending |
| req_ready | input | 1 | Engine accepts request |
| req_kind | output | 7 | Protocol selector |
| req_pec | output | 1 | Packet error checking requested |
| req_dev | output | 7 | Target device address |
| req_cmd | output | 8 | Command byte |
| req_count | output | 6 | Outgoing block length |
| rsp_valid | input | 1 | Engine result valid |
| rsp_code | input | 5 | Engine result code |
| rsp_count | input | 6 | Received block length |
| eng_rd_idx | input | 5 | Data byte index read by engine |
| eng_rd_byte | output | 8 | Data byte at eng_rd_idx |
| eng_wr_en | input | 1 | Engine data byte write strobe |
| eng_wr_idx | input | 5 | Data byte index written by engine |
| eng_wr_byte | input | 8 | Data byte written by engine |
| alm_valid | input | 1 | Alarm message received |
| alm_dst | input | 7 | Alarm destination address |
| alm_src | input | 7 | Alarm sender address |
| alm_d0 | input | 8 | Alarm data byte 0 |
| alm_d1 | input | 8 | Alarm data byte 1 |
| done_evt | output | 1 | Completion event pulse |

## Verification
A sequencer stuck in or skipping a state shows up within three cycles of the protocol write or the engine response. The symptoms are a missing or early `done_evt`, a protocol register still nonzero, or a status byte written late. A wrong validation decision appears at the ports in the cycle after the protocol write, as a request that should not exist or a missing one. The code in the status register shows the wrong reason two cycles later. A corrupted alarm latch or count register is visible on the next software read.

// File: rtl/smbx_pkg.sv
package smbx_pkg;

    localparam int REG_COUNT   = 40;
    localparam int DATA_BYTES  = 32;
    localparam int DATA_FIRST  = 4;
    localparam int IDXW        = $clog2(DATA_BYTES);
    localparam int CNTW        = IDXW + 1;

    localparam int OFF_PROTO    = 0;
    localparam int OFF_STATUS   = 1;
    localparam int OFF_ADDR     = 2;
    localparam int OFF_CMD      = 3;
    localparam int OFF_COUNT    = DATA_FIRST + DATA_BYTES;
    localparam int OFF_ALM_SRC  = OFF_COUNT + 1;
    localparam int OFF_ALM_D0   = OFF_COUNT + 2;
    localparam int OFF_ALM_D1   = OFF_COUNT + 3;

    localparam logic [6:0] K_FIRST  = 7'h02;
    localparam logic [6:0] K_SEND   = 7'h04;
    localparam logic [6:0] K_WRB    = 7'h06;
    localparam logic [6:0] K_BWR    = 7'h0A;
    localparam logic [6:0] K_BRD    = 7'h0B;
    localparam logic [6:0] K_BPCALL = 7'h0D;

    typedef logic [4:0] code_t;
    localparam code_t C_OK      = 5'h00;
    localparam code_t C_CMDDENY = 5'h12;
    localparam code_t C_BADLEN  = 5'h13;
    localparam code_t C_DEVDENY = 5'h17;
    localparam code_t C_NOPROTO = 5'h19;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_CHECK, SQ_ISSUE, SQ_WAIT, SQ_STATUS, SQ_CLEAR, SQ_EVENT
    } seq_st_e;

    typedef struct packed {
        logic       done;
        logic       alarm;
        logic       zero;
        code_t      code;
    } status_t;

    function automatic logic kind_reserved(input logic [6:0] k);
        return (k < K_FIRST) || (k > K_BPCALL);
    endfunction

    function automatic logic kind_has_cmd(input logic [6:0] k);
        return (k == K_SEND) || ((k >= K_WRB) && (k <= K_BPCALL));
    endfunction

    function automatic logic kind_rd_block(input logic [6:0] k);
        return (k == K_BRD) || (k == K_BPCALL);
    endfunction

endpackage

// File: rtl/smbx_reqchk.sv
module smbx_reqchk
    import smbx_pkg::*;
#(
    parameter int                 N_BA      = 2,
    parameter int                 N_BP      = 2,
    parameter logic [N_BA*7-1:0]  BLK_ADDRS = {7'h35, 7'h0C},
    parameter logic [N_BP*15-1:0] BLK_PAIRS = {7'h12, 8'h20, 7'h0B, 8'h3F}
) (
    input  logic [6:0]      kind_i,
    input  logic [6:0]      dev_i,
    input  logic [7:0]      cmd_i,
    input  logic [7:0]      wcnt_i,
    input  logic [CNTW-1:0] rcnt_i,
    output logic            ok_o,
    output code_t           code_o,
    output logic            rcnt_bad_o
);
    logic [N_BA-1:0] dev_hit;
    logic [N_BP-1:0] pair_hit;

    for (genvar i = 0; i < N_BA; i++) begin : g_dev
        assign dev_hit[i] = (dev_i == BLK_ADDRS[i*7 +: 7]);
    end

    for (genvar j = 0; j < N_BP; j++) begin : g_pair
        assign pair_hit[j] = (dev_i == BLK_PAIRS[j*15+8 +: 7]) &&
                             (cmd_i == BLK_PAIRS[j*15 +: 8]);
    end

    logic       wlen_bad;
    logic [7:0] wr_lim;
    logic [7:0] rd_lim;
    logic [7:0] rcnt_ext;

    always_comb begin
        wr_lim   = (kind_i == K_BPCALL) ? 8'd31 : 8'd32;
        wlen_bad = ((kind_i == K_BWR) || (kind_i == K_BPCALL)) &&
                   ((wcnt_i == 8'd0) || (wcnt_i > wr_lim));
        rd_lim   = (kind_i == K_BPCALL) ? (8'd32 - wcnt_i) : 8'd32;
        rcnt_ext = 8'(rcnt_i);
        rcnt_bad_o = (rcnt_ext == 8'd0) || (rcnt_ext > rd_lim);
    end

    always_comb begin
        if (kind_reserved(kind_i))                    code_o = C_NOPROTO;
        else if (|dev_hit)                            code_o = C_DEVDENY;
        else if (kind_has_cmd(kind_i) && |pair_hit)   code_o = C_CMDDENY;
        else if (wlen_bad)                            code_o = C_BADLEN;
        else                                          code_o = C_OK;
        ok_o = (code_o == C_OK);
    end
endmodule

// File: rtl/smbx_seq.sv
module smbx_seq
    import smbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  chk_ok_i,
    input  code_t chk_code_i,
    input  logic  req_ready_i,
    input  logic  rsp_valid_i,
    input  code_t rsp_code_i,
    input  logic  rd_block_i,
    input  logic  rcnt_bad_i,
    output logic  busy_o,
    output logic  req_valid_o,
    output logic  wait_o,
    output logic  sts_we_o,
    output logic  clr_o,
    output logic  evt_o,
    output code_t code_o
);
    seq_st_e st_q;
    code_t   code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            code_q <= C_OK;
        end else begin
            unique case (st_q)
                SQ_IDLE:   if (start_i) st_q <= SQ_CHECK;
                SQ_CHECK: begin
                    if (chk_ok_i) st_q <= SQ_ISSUE;
                    else begin
                        code_q <= chk_code_i;
                        st_q   <= SQ_STATUS;
                    end
                end
                SQ_ISSUE:  if (req_ready_i) st_q <= SQ_WAIT;
                SQ_WAIT: begin
                    if (rsp_valid_i) begin
                        if (rsp_code_i != C_OK)           code_q <= rsp_code_i;
                        else if (rd_block_i && rcnt_bad_i) code_q <= C_BADLEN;
                        else                               code_q <= C_OK;
                        st_q <= SQ_STATUS;
                    end
                end
                SQ_STATUS: st_q <= SQ_CLEAR;
                SQ_CLEAR:  st_q <= SQ_EVENT;
                SQ_EVENT:  st_q <= SQ_IDLE;
                default:   st_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o      = (st_q != SQ_IDLE);
    assign req_valid_o = (st_q == SQ_ISSUE);
    assign wait_o      = (st_q == SQ_WAIT);
    assign sts_we_o    = (st_q == SQ_STATUS);
    assign clr_o       = (st_q == SQ_CLEAR);
    assign evt_o       = (st_q == SQ_EVENT);
    assign code_o      = code_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        req_valid_o && !req_ready_i |=> req_valid_o) else $error("req dropped"); // R10
    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt_o |=> !evt_o) else $error("event longer than one cycle"); // R4
endmodule

// File: rtl/smbx_alarm.sv
module smbx_alarm #(
    parameter logic [6:0] HOST_ADDR = 7'h08
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       alm_valid_i,
    input  logic [6:0] alm_dst_i,
    input  logic [6:0] alm_src_i,
    input  logic [7:0] alm_d0_i,
    input  logic [7:0] alm_d1_i,
    input  logic       clr_i,
    output logic       flag_o,
    output logic [6:0] src_o,
    output logic [7:0] d0_o,
    output logic [7:0] d1_o
);
    logic take;
    assign take = alm_valid_i && (alm_dst_i == HOST_ADDR) && !flag_o && !clr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            src_o  <= '0;
            d0_o   <= '0;
            d1_o   <= '0;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end else if (take) begin
            flag_o <= 1'b1;
            src_o  <= alm_src_i;
            d0_o   <= alm_d0_i;
            d1_o   <= alm_d1_i;
        end
    end

    AST_ALARM_LOCKED: assert property (@(posedge clk) disable iff (rst)
        flag_o && !clr_i |=> flag_o && $stable(src_o) && $stable(d0_o) && $stable(d1_o))
        else $error("latched alarm overwritten"); // R12
endmodule

// File: rtl/smbx_host_regs.sv
module smbx_host_regs
    import smbx_pkg::*;
#(
    parameter int                 AW        = 8,
    parameter logic [AW-1:0]      BASE      = 8'h20,
    parameter logic [6:0]         HOST_ADDR = 7'h08,
    parameter int                 N_BA      = 2,
    parameter int                 N_BP      = 2,
    parameter logic [N_BA*7-1:0]  BLK_ADDRS = {7'h35, 7'h0C},
    parameter logic [N_BP*15-1:0] BLK_PAIRS = {7'h12, 8'h20, 7'h0B, 8'h3F}
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   sw_addr,
    input  logic            sw_we,
    input  logic [7:0]      sw_wdata,
    output logic [7:0]      sw_rdata,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [6:0]      req_kind,
    output logic            req_pec,
    output logic [6:0]      req_dev,
    output logic [7:0]      req_cmd,
    output logic [CNTW-1:0] req_count,
    input  logic            rsp_valid,
    input  logic [4:0]      rsp_code,
    input  logic [CNTW-1:0] rsp_count,
    input  logic [IDXW-1:0] eng_rd_idx,
    output logic [7:0]      eng_rd_byte,
    input  logic            eng_wr_en,
    input  logic [IDXW-1:0] eng_wr_idx,
    input  logic [7:0]      eng_wr_byte,
    input  logic            alm_valid,
    input  logic [6:0]      alm_dst,
    input  logic [6:0]      alm_src,
    input  logic [7:0]      alm_d0,
    input  logic [7:0]      alm_d1,
    output logic            done_evt
);
    logic [AW-1:0]   off;
    logic            hit, sw_wr, acc, start, sts_clear;
    logic            in_data;
    logic [IDXW-1:0] sw_idx;

    assign off       = sw_addr - BASE;
    assign hit       = (sw_addr >= BASE) && (off < AW'(REG_COUNT));
    assign sw_wr     = sw_we && hit;
    assign in_data   = (off >= AW'(DATA_FIRST)) && (off < AW'(OFF_COUNT));
    assign sw_idx    = IDXW'(off - AW'(DATA_FIRST));

    logic [7:0] proto_q, addr_q, cmd_q, cnt_q;
    logic       done_q;
    code_t      code_q;
    logic [7:0] data_q [DATA_BYTES];

    logic  busy, wait_st, sts_we, proto_clr;
    code_t seq_code;
    logic  chk_ok, rcnt_bad;
    code_t chk_code;
    logic  alm_flag;
    logic [6:0] alm_src_q;
    logic [7:0] alm_d0_q, alm_d1_q;

    assign acc       = sw_wr && !busy;
    assign start     = acc && (off == AW'(OFF_PROTO)) && (sw_wdata != 8'h00);
    assign sts_clear = sw_wr && (off == AW'(OFF_STATUS)) && (sw_wdata == 8'h00);

    smbx_reqchk #(.N_BA(N_BA), .N_BP(N_BP), .BLK_ADDRS(BLK_ADDRS), .BLK_PAIRS(BLK_PAIRS)) u_chk (
        .kind_i(proto_q[6:0]), .dev_i(addr_q[7:1]), .cmd_i(cmd_q), .wcnt_i(cnt_q),
        .rcnt_i(rsp_count), .ok_o(chk_ok), .code_o(chk_code), .rcnt_bad_o(rcnt_bad)
    );

    smbx_seq u_seq (
        .clk(clk), .rst(rst), .start_i(start), .chk_ok_i(chk_ok), .chk_code_i(chk_code),
        .req_ready_i(req_ready), .rsp_valid_i(rsp_valid), .rsp_code_i(rsp_code),
        .rd_block_i(kind_rd_block(proto_q[6:0])), .rcnt_bad_i(rcnt_bad),
        .busy_o(busy), .req_valid_o(req_valid), .wait_o(wait_st), .sts_we_o(sts_we),
        .clr_o(proto_clr), .evt_o(done_evt), .code_o(seq_code)
    );

    smbx_alarm #(.HOST_ADDR(HOST_ADDR)) u_alarm (
        .clk(clk), .rst(rst), .alm_valid_i(alm_valid), .alm_dst_i(alm_dst),
        .alm_src_i(alm_src), .alm_d0_i(alm_d0), .alm_d1_i(alm_d1), .clr_i(sts_clear),
        .flag_o(alm_flag), .src_o(alm_src_q), .d0_o(alm_d0_q), .d1_o(alm_d1_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            proto_q <= '0;
            addr_q  <= '0;
            cmd_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            code_q  <= C_OK;
            for (int i = 0; i < DATA_BYTES; i++) data_q[i] <= '0;
        end else begin
            if (proto_clr)   proto_q <= 8'h00;
            else if (start)  proto_q <= sw_wdata;

            if (start || sts_clear) begin
                done_q <= 1'b0;
                code_q <= C_OK;
            end else if (sts_we) begin
                done_q <= (seq_code == C_OK);
                code_q <= seq_code;
            end

            if (acc && off == AW'(OFF_ADDR)) addr_q <= sw_wdata;
            if (acc && off == AW'(OFF_CMD))  cmd_q  <= sw_wdata;

            if (wait_st && rsp_valid && kind_rd_block(proto_q[6:0]))
                cnt_q <= 8'(rsp_count);
            else if (acc && off == AW'(OFF_COUNT))
                cnt_q <= sw_wdata;

            if (eng_wr_en)              data_q[eng_wr_idx] <= eng_wr_byte;
            else if (acc && in_data)    data_q[sw_idx]     <= sw_wdata;
        end
    end

    status_t sts;
    assign sts = '{done: done_q, alarm: alm_flag, zero: 1'b0, code: code_q};

    always_comb begin
        sw_rdata = 8'h00;
        if (hit) begin
            if (in_data) sw_rdata = data_q[sw_idx];
            else begin
                unique case (off)
                    AW'(OFF_PROTO):   sw_rdata = proto_q;
                    AW'(OFF_STATUS):  sw_rdata = sts;
                    AW'(OFF_ADDR):    sw_rdata = addr_q;
                    AW'(OFF_CMD):     sw_rdata = cmd_q;
                    AW'(OFF_COUNT):   sw_rdata = cnt_q;
                    AW'(OFF_ALM_SRC): sw_rdata = {alm_src_q, 1'b0};
                    AW'(OFF_ALM_D0):  sw_rdata = alm_d0_q;
                    AW'(OFF_ALM_D1):  sw_rdata = alm_d1_q;
                    default:          sw_rdata = 8'h00;
                endcase
            end
        end
    end

    assign req_kind    = proto_q[6:0];
    assign req_pec     = proto_q[7];
    assign req_dev     = addr_q[7:1];
    assign req_cmd     = cmd_q;
    assign req_count   = cnt_q[CNTW-1:0];
    assign eng_rd_byte = data_q[eng_rd_idx];

    AST_EVT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        done_evt |-> (proto_q == 8'h00) && ($past(proto_q) != 8'h00))
        else $error("event not right after protocol clear"); // R4
    AST_STATUS_BEFORE_EVT: assert property (@(posedge clk) disable iff (rst)
        done_evt |-> (done_q != (code_q != C_OK)))
        else $error("event before status written"); // R5
    AST_NO_FILTERED_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> chk_ok)
        else $error("rejected request issued"); // R7
    AST_BUSY_PROTO_STABLE: assert property (@(posedge clk) disable iff (rst)
        busy && !proto_clr |=> $stable(proto_q) && $stable(addr_q) && $stable(cmd_q))
        else $error("register changed in flight"); // R11
endmodule

// File: tb/smbx_host_regs_tb.sv
`timescale 1ns/1ps
module smbx_host_regs_tb;
    localparam logic [7:0] TB_BASE = 8'h20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sw_addr = '0;
    logic       sw_we = 1'b0;
    logic [7:0] sw_wdata = '0;
    logic [7:0] sw_rdata;
    logic       req_valid, req_pec;
    logic       req_ready = 1'b0;
    logic [6:0] req_kind, req_dev;
    logic [7:0] req_cmd;
    logic [5:0] req_count;
    logic       rsp_valid = 1'b0;
    logic [4:0] rsp_code = '0;
    logic [5:0] rsp_count = '0;
    logic [4:0] eng_rd_idx = '0;
    logic [7:0] eng_rd_byte;
    logic       eng_wr_en = 1'b0;
    logic [4:0] eng_wr_idx = '0;
    logic [7:0] eng_wr_byte = '0;
    logic       alm_valid = 1'b0;
    logic [6:0] alm_dst = '0, alm_src = '0;
    logic [7:0] alm_d0 = '0, alm_d1 = '0;
    logic       done_evt;

    always #2 clk = ~clk;

    smbx_host_regs #(.BASE(TB_BASE)) u_dut (
        .clk(clk), .rst(rst), .sw_addr(sw_addr), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_pec(req_pec), .req_dev(req_dev), .req_cmd(req_cmd),
        .req_count(req_count), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_count(rsp_count), .eng_rd_idx(eng_rd_idx), .eng_rd_byte(eng_rd_byte),
        .eng_wr_en(eng_wr_en), .eng_wr_idx(eng_wr_idx), .eng_wr_byte(eng_wr_byte),
        .alm_valid(alm_valid), .alm_dst(alm_dst), .alm_src(alm_src), .alm_d0(alm_d0),
        .alm_d1(alm_d1), .done_evt(done_evt)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int off, input logic [7:0] v);
        @(negedge clk);
        sw_addr  = 8'(int'(TB_BASE) + off);
        sw_wdata = v;
        sw_we    = 1'b1;
        @(negedge clk);
        sw_we    = 1'b0;
    endtask

    task automatic rd(input int off, output logic [7:0] v);
        sw_addr = 8'(int'(TB_BASE) + off);
        #0.1;
        v = sw_rdata;
    endtask

    // fields: proto, addr reg, cmd, count, engine code, engine count, issue expected, final code
    localparam int NV = 23;
    localparam logic [63:0] VEC [NV] = '{
        64'h07_2C_0D_00_00_01_01_00, 64'h89_2C_0D_00_1F_02_01_1F,
        64'h0E_2C_0D_00_00_00_00_19, 64'h01_2C_0D_00_00_00_00_19,
        64'h06_18_0D_00_00_00_00_17, 64'h09_16_3F_00_00_00_00_12,
        64'h03_16_3F_00_10_00_01_10, 64'h0A_2C_01_00_00_00_00_13,
        64'h0A_2C_01_21_00_00_00_13, 64'h0A_2C_01_20_00_00_01_00,
        64'h0D_2C_01_20_00_00_00_13, 64'h0D_2C_01_1F_00_01_01_00,
        64'h0D_2C_01_1F_00_02_01_13, 64'h0B_2C_01_00_00_28_01_13,
        64'h0B_2C_01_00_00_00_01_13, 64'h8B_2C_01_00_00_20_01_00,
        64'h05_18_00_00_00_00_00_17, 64'h0B_16_3F_00_00_05_00_12,
        64'h7F_18_00_00_00_00_00_19, 64'h0A_18_01_00_00_00_00_17,
        64'h0C_24_20_00_00_00_00_12, 64'h04_24_21_00_00_00_01_00,
        64'h02_24_20_00_18_00_01_18
    };

    task automatic run_txn(input logic [7:0] pr, ad, cm, ct, input logic [4:0] rc,
                           input logic [5:0] rn, output bit issued, output bit evt,
                           output logic [31:0] fields);
        wr(2, ad); wr(3, cm); wr(36, ct); wr(0, pr);
        issued = 1'b0; evt = 1'b0; fields = '0;
        for (int c = 0; c < 40 && !evt; c++) begin
            @(negedge clk);
            if (done_evt) evt = 1'b1;
            else if (req_valid && !issued) begin
                issued = 1'b1;
                fields = {req_pec, req_kind, 1'b0, req_dev, req_cmd, 2'b00, req_count};
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                rsp_valid = 1'b1; rsp_code = rc; rsp_count = rn;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    endtask

    initial begin
        #(4.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, p, s;
        logic [7:0] orv;
        bit iss, ev;
        logic [31:0] fl;
        int cs, cp, ce;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        orv = 8'h00;
        for (int i = 0; i < 40; i++) begin rd(i, v); orv |= v; end
        check("R1 regs", {24'h0, orv}, 32'h0);
        check("R1 req/evt", {30'h0, req_valid, done_evt}, 32'h0);

        // vector walk: R3 R5 R6 R7 R8 R9 R10
        for (int k = 0; k < NV; k++) begin
            logic [63:0] e;
            string tg;
            e = VEC[k];
            run_txn(e[63:56], e[55:48], e[47:40], e[39:32], e[28:24], e[21:16], iss, ev, fl);
            if (e[4:0] == 5'h19) tg = "R6";
            else if (e[4:0] == 5'h17 || e[4:0] == 5'h12) tg = "R7";
            else if (e[4:0] == 5'h13 && e[8] == 1'b0) tg = "R8";
            else if (e[4:0] == 5'h13) tg = "R9";
            else tg = "R10";
            check({tg, " issue"}, {31'h0, iss}, {31'h0, e[8]});
            check("R4 event", {31'h0, ev}, 32'h1);
            rd(1, s);
            check({tg, " R5 status"}, {24'h0, s}, {24'h0, (e[4:0] == 5'h0), 2'b00, e[4:0]});
            rd(0, p);
            check("R4 proto cleared", {24'h0, p}, 32'h0);
            if (e[8])
                check("R10 fields", fl, {e[63], e[62:56], 1'b0, e[55:49], e[47:40], 2'b00, e[37:32]});
            if (e[8] && e[4:0] == 5'h0 && (e[62:56] == 7'h0B || e[62:56] == 7'h0D)) begin
                rd(36, v);
                check("R9 count", {24'h0, v}, {26'h0, e[21:16]});
            end
        end

        // R4: ordering, reserved selector path
        wr(0, 8'h0E);
        cs = -1; cp = -1; ce = -1;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            rd(1, s); rd(0, p);
            if (cs < 0 && s != 8'h00) cs = c;
            if (cp < 0 && p == 8'h00) cp = c;
            if (ce < 0 && done_evt) ce = c;
        end
        check("R4 clear after status", cp, cs + 1);
        check("R4 event with clear", ce, cp);

        // R3: writing 0 starts nothing
        wr(0, 8'h00);
        ev = 1'b0;
        for (int c = 0; c < 6; c++) begin @(negedge clk); if (done_evt || req_valid) ev = 1'b1; end
        check("R3 zero write idle", {31'h0, ev}, 32'h0);

        // R11: writes ignored in flight
        wr(2, 8'h2C); wr(0, 8'h07);
        @(negedge clk);
        check("R11 request up", {31'h0, req_valid}, 32'h1);
        wr(0, 8'h05); wr(2, 8'h50);
        rd(0, p); rd(2, v);
        check("R11 proto held", {24'h0, p}, 32'h07);
        check("R11 addr held", {24'h0, v}, 32'h2C);
        req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
        rsp_valid = 1'b1; rsp_code = 5'h00; @(negedge clk); rsp_valid = 1'b0;
        repeat (4) @(negedge clk);

        // R12: alarm capture and lock
        alm_valid = 1'b1; alm_dst = 7'h10; alm_src = 7'h33; alm_d0 = 8'h01; alm_d1 = 8'h02;
        @(negedge clk); alm_valid = 1'b0;
        rd(1, s);
        check("R12 foreign dst ignored", {31'h0, s[6]}, 32'h0);
        alm_valid = 1'b1; alm_dst = 7'h08; alm_src = 7'h0A; alm_d0 = 8'h11; alm_d1 = 8'h22;
        @(negedge clk); alm_valid = 1'b0;
        rd(1, s); rd(37, v);
        check("R12 alarm bit", {31'h0, s[6]}, 32'h1);
        check("R12 sender", {24'h0, v}, 32'h14);
        alm_valid = 1'b1; alm_src = 7'h0B; alm_d0 = 8'h77; alm_d1 = 8'h66;
        @(negedge clk); alm_valid = 1'b0;
        rd(37, v); rd(38, p); rd(39, s);
        check("R12 locked", {8'h0, v, p, s}, {8'h0, 8'h14, 8'h11, 8'h22});

        // R3: transaction keeps alarm bit
        run_txn(8'h07, 8'h2C, 8'h01, 8'h00, 5'h00, 6'h01, iss, ev, fl);
        rd(1, s);
        check("R3 alarm kept", {24'h0, s}, 32'hC0);

        // R13: non-zero status write ignored, zero clears
        wr(1, 8'h40);
        rd(1, s);
        check("R13 nonzero ignored", {24'h0, s}, 32'hC0);
        wr(1, 8'h00);
        rd(1, s);
        check("R13 cleared", {24'h0, s}, 32'h00);
        alm_valid = 1'b1; alm_src = 7'h0B;
        @(negedge clk); alm_valid = 1'b0;
        rd(37, v);
        check("R13 new alarm after clear", {24'h0, v}, 32'h16);

        // R14: engine data port
        @(negedge clk);
        eng_wr_en = 1'b1; eng_wr_idx = 5'd3; eng_wr_byte = 8'hA5;
        @(negedge clk); eng_wr_en = 1'b0;
        rd(7, v);
        check("R14 engine write", {24'h0, v}, 32'hA5);
        wr(14, 8'h5C);
        eng_rd_idx = 5'd10; #0.1;
        check("R14 engine read", {24'h0, eng_rd_byte}, 32'h5C);
        wr(35, 8'h3E);
        eng_rd_idx = 5'd31; #0.1;
        check("R14 last byte", {24'h0, eng_rd_byte}, 32'h3E);

        // R2: window bounds
        rd(-1, v);
        check("R2 below window", {24'h0, v}, 32'h0);
        rd(40, v);
        check("R2 above window", {24'h0, v}, 32'h0);
        wr(40, 8'h07);
        ev = 1'b0;
        for (int c = 0; c < 6; c++) begin @(negedge clk); if (done_evt || req_valid) ev = 1'b1; end
        rd(0, p);
        check("R2 outside write", {23'h0, ev, p}, 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule